// File: doc/BRIEF.md
# SCSI Initiator Bus Command Register

This block is the host-writable control register that an initiator-side parallel SCSI controller uses to drive the bus control lines directly. Three command bits drive BSY, SEL and ATN. A fourth command bit asks for the data-bus drivers. The block also stores the output data byte and a target-mode flag. The host reaches all of this through a plain byte write/read port with a small address field.

The data-bus drivers are gated by the bus itself. The sensed phase lines (C/D, I/O, MSG) go through a multi-flop synchronizer. Their synchronized value is compared against an expected-phase field that comes from the target-command register elsewhere in the controller. Drive starts only when the data-bus command bit is set, the device is not in target mode, the sensed I/O line is low and the phase matches. This enable is registered. While it is active, the data byte is driven together with a generated odd-parity bit.

Every output is an active-low, open-drain style enable: 0 pulls the line low (asserted) and 1 leaves it undriven. The software sees the bus as asserted signals, so a data bit or parity bit of 1 is driven as 0.

Top module: `bus_cmd_reg`

## Requirements
- R1: A synchronous active-high reset clears the command bits, the data byte and the target-mode flag. Every drive output then reads 1 (released), and every register reads back 0.
- R2: Writing the command register (address 0) with bit 0 set drives `bsy_drv_n` to 0 from the clock edge of the write. Writing it with bit 0 clear releases `bsy_drv_n` to 1.
- R3: Command bit 1 drives `sel_drv_n` low when set and releases it when clear, with the same timing as R2.
- R4: Command bit 2 drives `atn_drv_n` low only while the target-mode flag (address 2, bit 0) is 0. While the flag is 1, the bit is still stored and read back but ATN stays released. Clearing the flag drives ATN at once.
- R5: One write to the command register with bits 1 and 2 both set drives SEL and ATN in the same cycle.
- R6: A read returns the stored value without side effects. The command register returns bits 3:0 with the upper bits as 0. Address 1 returns the data byte. Address 2 returns the flag in bit 0. Address 3 reads 0 and ignores writes.
- R7: While the data drive is enabled, `db_drv_n` equals the bitwise inverse of the data byte (address 1). `dbp_drv_n` is the inverse of an odd-parity bit, so the nine asserted bits hold an odd number of ones. The data byte may be rewritten while driving, and the outputs follow from that write's edge.
- R8: The data drive is enabled only when all of these hold: command bit 3 is set, the target flag is 0, the synchronized I/O line is 0, and the synchronized phase equals `exp_phase`. Phase encoding is bit 0 = C/D, bit 1 = I/O, bit 2 = MSG. Otherwise all of `db_drv_n` and `dbp_drv_n` read 1.
- R9: A change on `bus_phase` takes effect on the data drive at the (SYNC_STAGES+1)-th rising edge after it is applied, which is the third edge with the default of 2 stages.
- R10: Setting or clearing command bit 3, or changing the target flag, changes the data drive one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Write strobe for one cycle |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, combinational from address |
| bus_phase | input | 3 | Sensed phase lines, asynchronous {MSG, I/O, C/D}, 1 = asserted |
| exp_phase | input | 3 | Expected phase from the target-command register, same encoding |
| bsy_drv_n | output | 1 | BSY drive, 0 = pull low |
| sel_drv_n | output | 1 | SEL drive, 0 = pull low |
| atn_drv_n | output | 1 | ATN drive, 0 = pull low |
| db_drv_n | output | DATA_W | Data line drives, 0 = pull low |
| dbp_drv_n | output | 1 | Parity line drive, 0 = pull low |

## Verification
Two functions can land in the same cycle. The first is a host write that changes the data-bus command bit or the target flag. The second is the phase-qualified enable register latching a new comparison result. The bench provokes this by clearing the command bit or setting target mode while the phase matches and the drive is on. It checks that the drive is still on at the sample right after the write edge and released at the next one. Phase changes are judged by sampling before and at the third edge to pin the synchronizer latency. A single write carrying both SEL and ATN is checked for both lines in the same sample.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
   localparam int BCR_ADDR_CMD  = 0;
   localparam int BCR_ADDR_DATA = 1;
   localparam int BCR_ADDR_MODE = 2;

   localparam int BCR_CMD_BITS  = 4;
   localparam int BCR_PH_CD     = 0;
   localparam int BCR_PH_IO     = 1;
   localparam int BCR_PH_MSG    = 2;
   localparam int BCR_PH_W      = 3;

   typedef struct packed {
      logic db;
      logic atn;
      logic sel;
      logic bsy;
   } bcr_cmd_t;
endpackage

// File: rtl/bcr_phase_sync.sv
module bcr_phase_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bcr_phase_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg[0] <= '0;
               else     stg[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stg[s] <= '0;
               else     stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/bcr_host_regs.sv
module bcr_host_regs
   import bcr_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output bcr_cmd_t          cmd_o,
   output logic [DATA_W-1:0] odata_o,
   output logic              target_o
);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(BCR_ADDR_CMD);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BCR_ADDR_DATA);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(BCR_ADDR_MODE);

   bcr_cmd_t          cmd_q;
   logic [DATA_W-1:0] odata_q;
   logic              tgt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q   <= '0;
         odata_q <= '0;
         tgt_q   <= 1'b0;
      end else if (wr) begin
         if (addr == A_CMD)  cmd_q   <= bcr_cmd_t'(wdata[BCR_CMD_BITS-1:0]);
         if (addr == A_DATA) odata_q <= wdata;
         if (addr == A_MODE) tgt_q   <= wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CMD)       rdata[BCR_CMD_BITS-1:0] = cmd_q;
      else if (addr == A_DATA) rdata = odata_q;
      else if (addr == A_MODE) rdata[0] = tgt_q;
   end

   assign cmd_o    = cmd_q;
   assign odata_o  = odata_q;
   assign target_o = tgt_q;
endmodule

// File: rtl/bcr_drive.sv
module bcr_drive
   import bcr_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit ODD_PARITY = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  bcr_cmd_t            cmd,
   input  logic [DATA_W-1:0]   odata,
   input  logic                target,
   input  logic [BCR_PH_W-1:0] ph_sync,
   input  logic [BCR_PH_W-1:0] exp_phase,
   output logic                bsy_drv_n,
   output logic                sel_drv_n,
   output logic                atn_drv_n,
   output logic [DATA_W-1:0]   db_drv_n,
   output logic                dbp_drv_n
);
   logic en_q;
   logic par;
   logic qual;

   assign qual = cmd.db && !target && !ph_sync[BCR_PH_IO] && (ph_sync == exp_phase);

   always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= qual;
   end

   generate
      if (ODD_PARITY) begin : g_odd
         assign par = ~^odata;
         a_r7_odd_count: assert property (@(posedge clk) disable iff (rst)
            en_q |-> (^(~{db_drv_n, dbp_drv_n})) == 1'b1);
      end else begin : g_even
         assign par = ^odata;
      end
   endgenerate

   assign bsy_drv_n = ~cmd.bsy;
   assign sel_drv_n = ~cmd.sel;
   assign atn_drv_n = ~(cmd.atn && !target);
   assign db_drv_n  = en_q ? ~odata : '1;
   assign dbp_drv_n = en_q ? ~par   : 1'b1;

   // R8: an active drive always follows a cycle with I/O low and a phase match
   a_r8_phase_qualified: assert property (@(posedge clk) disable iff (rst)
      !(&db_drv_n && dbp_drv_n) |-> $past(!ph_sync[BCR_PH_IO] && ph_sync == exp_phase));
endmodule

// File: rtl/bus_cmd_reg.sv
module bus_cmd_reg
   import bcr_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [2:0]        bus_phase,
   input  logic [2:0]        exp_phase,
   output logic              bsy_drv_n,
   output logic              sel_drv_n,
   output logic              atn_drv_n,
   output logic [DATA_W-1:0] db_drv_n,
   output logic              dbp_drv_n
);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(BCR_ADDR_CMD);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("bus_cmd_reg: ADDR_W must be at least 2");
      end
      if (DATA_W < BCR_CMD_BITS) begin : g_bad_data
         $error("bus_cmd_reg: DATA_W must hold the command bits");
      end
   endgenerate

   bcr_cmd_t              cmd;
   logic [DATA_W-1:0]     odata;
   logic                  target;
   logic [BCR_PH_W-1:0]   ph_sync;

   bcr_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
      .rdata(host_rdata), .cmd_o(cmd), .odata_o(odata), .target_o(target)
   );

   bcr_phase_sync #(.STAGES(SYNC_STAGES), .WIDTH(BCR_PH_W)) u_sync (
      .clk(clk), .rst(rst), .async_i(bus_phase), .sync_o(ph_sync)
   );

   bcr_drive #(.DATA_W(DATA_W), .ODD_PARITY(1'b1)) u_drive (
      .clk(clk), .rst(rst), .cmd(cmd), .odata(odata), .target(target),
      .ph_sync(ph_sync), .exp_phase(exp_phase),
      .bsy_drv_n(bsy_drv_n), .sel_drv_n(sel_drv_n), .atn_drv_n(atn_drv_n),
      .db_drv_n(db_drv_n), .dbp_drv_n(dbp_drv_n)
   );

   logic cmd_wr;
   assign cmd_wr = host_wr && (host_addr == A_CMD);

   a_r2_bsy_set: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && host_wdata[0]) |=> !bsy_drv_n);
   a_r2_bsy_clr: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && !host_wdata[0]) |=> bsy_drv_n);
   a_r3_sel_set: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && host_wdata[1]) |=> !sel_drv_n);
   a_r4_no_atn_in_target: assert property (@(posedge clk) disable iff (rst)
      target |-> atn_drv_n);
   a_r5_sel_atn_together: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && host_wdata[1] && host_wdata[2] && !target) |=> (!sel_drv_n && !atn_drv_n));
   a_r10_db_off: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && !host_wdata[3]) |=> ##1 (&db_drv_n && dbp_drv_n));
endmodule

// File: tb/bus_cmd_reg_tb.sv
module bus_cmd_reg_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       host_wr = 1'b0;
   logic [1:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic [2:0] bus_phase = '0;
   logic [2:0] exp_phase = '0;
   logic       bsy_drv_n, sel_drv_n, atn_drv_n, dbp_drv_n;
   logic [7:0] db_drv_n;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   bus_cmd_reg u_dut (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_phase(bus_phase),
      .exp_phase(exp_phase), .bsy_drv_n(bsy_drv_n), .sel_drv_n(sel_drv_n),
      .atn_drv_n(atn_drv_n), .db_drv_n(db_drv_n), .dbp_drv_n(dbp_drv_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   function automatic logic [8:0] drive_of(input logic [7:0] d);
      logic p = ~^d;
      return {~d, ~p};
   endfunction

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 ctrl released", {bsy_drv_n, sel_drv_n, atn_drv_n}, 3'b111);
      chk("R1 data released", {db_drv_n, dbp_drv_n}, 9'h1FF);
      for (int a = 0; a < 3; a++) begin
         rd(2'(a), v);
         chk("R1 reg zero", v, 8'h00);
      end
   endtask

   task automatic t_bsy_sel();
      logic [7:0] v;
      wr(2'd0, 8'h01);
      chk("R2 bsy driven", {bsy_drv_n, sel_drv_n, atn_drv_n}, 3'b011);
      wr(2'd0, 8'h00);
      chk("R2 bsy released", bsy_drv_n, 1'b1);
      wr(2'd0, 8'h02);
      chk("R3 sel driven", {bsy_drv_n, sel_drv_n, atn_drv_n}, 3'b101);
      rd(2'd0, v);
      chk("R6 cmd readback", v, 8'h02);
      wr(2'd0, 8'h00);
      chk("R3 sel released", sel_drv_n, 1'b1);
   endtask

   task automatic t_sel_atn();
      wr(2'd0, 8'h06);
      chk("R5 sel+atn one write", {sel_drv_n, atn_drv_n}, 2'b00);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_atn_target();
      logic [7:0] v;
      wr(2'd2, 8'h01);
      wr(2'd0, 8'h04);
      chk("R4 atn held off in target", atn_drv_n, 1'b1);
      rd(2'd0, v);
      chk("R4 atn bit stored", v, 8'h04);
      rd(2'd2, v);
      chk("R6 mode readback", v, 8'h01);
      wr(2'd2, 8'h00);
      chk("R4 atn after target clear", atn_drv_n, 1'b0);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_read_and_unused();
      logic [7:0] v1, v2;
      wr(2'd1, 8'h5A);
      wr(2'd3, 8'hFF);
      rd(2'd1, v1);
      rd(2'd1, v2);
      chk("R6 data read repeat", {v1, v2}, 16'h5A5A);
      rd(2'd3, v1);
      chk("R6 unused reads zero", v1, 8'h00);
      rd(2'd0, v1);
      chk("R6 unused write ignored", {v1, bsy_drv_n, sel_drv_n, atn_drv_n, db_drv_n, dbp_drv_n},
          {8'h00, 3'b111, 9'h1FF});
   endtask

   task automatic t_data();
      exp_phase = 3'b000;
      wr(2'd1, 8'hA5);
      wr(2'd0, 8'h08);
      chk("R10 not yet driving", {db_drv_n, dbp_drv_n}, 9'h1FF);
      @(negedge clk);
      chk("R7 drive A5", {db_drv_n, dbp_drv_n}, drive_of(8'hA5));
      wr(2'd1, 8'h07);
      chk("R7 drive 07", {db_drv_n, dbp_drv_n}, drive_of(8'h07));
   endtask

   task automatic t_phase();
      @(negedge clk); bus_phase = 3'b001;
      repeat (2) @(negedge clk);
      chk("R9 mismatch not seen before 3rd edge", {db_drv_n, dbp_drv_n}, drive_of(8'h07));
      @(negedge clk);
      chk("R8 phase mismatch off", {db_drv_n, dbp_drv_n}, 9'h1FF);
      @(negedge clk); bus_phase = 3'b000;
      repeat (2) @(negedge clk);
      chk("R9 match not seen before 3rd edge", {db_drv_n, dbp_drv_n}, 9'h1FF);
      @(negedge clk);
      chk("R9 match at 3rd edge", {db_drv_n, dbp_drv_n}, drive_of(8'h07));
      @(negedge clk); bus_phase = 3'b010; exp_phase = 3'b010;
      repeat (4) @(negedge clk);
      chk("R8 io high off", {db_drv_n, dbp_drv_n}, 9'h1FF);
      @(negedge clk); bus_phase = 3'b101; exp_phase = 3'b101;
      repeat (4) @(negedge clk);
      chk("R8 msg+cd match on", {db_drv_n, dbp_drv_n}, drive_of(8'h07));
      wr(2'd2, 8'h01);
      chk("R10 target write same cycle", {db_drv_n, dbp_drv_n}, drive_of(8'h07));
      @(negedge clk);
      chk("R8 target mode off", {db_drv_n, dbp_drv_n}, 9'h1FF);
      wr(2'd2, 8'h00);
      @(negedge clk);
   endtask

   task automatic t_clear();
      chk("R10 on before clear", {db_drv_n, dbp_drv_n}, drive_of(8'h07));
      wr(2'd0, 8'h00);
      chk("R10 still on at write edge", {db_drv_n, dbp_drv_n}, drive_of(8'h07));
      @(negedge clk);
      chk("R10 off one edge later", {db_drv_n, dbp_drv_n}, 9'h1FF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_bsy_sel();
      t_sel_atn();
      t_atn_target();
      t_read_and_unused();
      t_data();
      t_phase();
      t_clear();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule